// File: doc/BRIEF.md
# Temperature Limit Alarm and Alert Latch

This block sits behind a two-channel temperature converter. Each time the converter signals that a conversion has finished, the two signed readings are compared against a high and a low limit kept for each channel. Each comparison that trips sets a sticky flag in an eight-bit status byte. An open sensing diode also sets a flag. A fan failure sets a flag too, provided fan detection is enabled. A status read clears the flags. After the read, each flag takes the value that the most recent conversion produced, so a condition that still holds stays visible.

Separately from the status flags, an active-low alert output is latched whenever a flag event occurs and alerts are not masked. Reading the status byte does not release the alert. The alert is released by an alert-response read. While the alert is active, the response byte carries the block's 7-bit bus address in its upper bits. An alert caused by a fan failure is released only after fan detection has been switched off in the configuration byte. Limits and configuration are loaded through a simple register write port. The bus physical layer and the converter are outside this block.

Top module: `thermal_alert_unit`

## Requirements
- R1: After reset, all status flags are 0, alert_n is 1 and ara_data is 0xFF. The high limits are 0x7F (+127) and the low limits are 0xC9 (-55). The mask bit is 0 and the fan-detect enable is 1.
- R2: Readings and limits are 8-bit two's complement with 1 °C per LSB. On a cycle with conv_done high, a channel's high event is reading >= high limit and its low event is reading <= low limit. The open event is diode_open, and the fan event is fan_fail AND fan-detect enable. Without conv_done, the inputs set nothing.
- R3: status is {busy, high ch2, low ch2, high ch1, low ch1, open diode, 0, fan fail}, from bit 7 down to bit 0. Bit 7 follows busy combinationally, and bit 1 always reads 0.
- R4: Flags are sticky. A stat_rd cycle replaces every flag with the event value of the latest conversion. A flag whose event occurs in the same cycle as stat_rd ends up set.
- R5: A conversion with any event while unmasked drives alert_n low from the next cycle. alert_n stays low across status reads until it is released by an alert-response read.
- R6: Configuration bit 7 is the mask. While it is 1, alert_n is 1 and no conversion latches an alert.
- R7: While alert_n is low, ara_data is {7'h3D, 0} = 0x7A; otherwise it is 0xFF. An ara_rd cycle releases a temperature or diode alert unless a new event is latched in that same cycle.
- R8: Configuration bit 0 is the fan-detect enable. A latched fan alert survives ara_rd while that bit is 1 and is released by ara_rd once the bit is 0.
- R9: wr_sel selects the target of a write: 0 is the ch1 high limit, 1 the ch1 low limit, 2 the ch2 high limit, 3 the ch2 low limit, and 4 the configuration byte. Values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: new readings are valid |
| temp_ch1 | input | 8 | Channel 1 reading, two's complement |
| temp_ch2 | input | 8 | Channel 2 reading, two's complement |
| diode_open | input | 1 | Open-diode fault from the converter |
| fan_fail | input | 1 | Fan failure indication |
| busy | input | 1 | Converter busy, shown in status bit 7 |
| stat_rd | input | 1 | Status-read strobe |
| ara_rd | input | 1 | Alert-response-read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Status byte |
| alert_n | output | 1 | Latched alert, active low |
| ara_data | output | 8 | Alert-response byte |

## Verification
The assertions assume that every strobe is a synchronous level sampled at the rising edge. They also assume that conv_done, stat_rd and ara_rd may coincide in any combination, and that the readings are only meaningful in a conv_done cycle. The stimulus drives every input on the falling edge and holds it for whole cycles. It deliberately makes strobes coincide to reach the set-wins cases. The bench sweeps every 8-bit reading against fixed limits on both channels. Between readings it clears the flags through a neutral conversion, so that each comparison is observed on its own.

// File: rtl/thal_pkg.sv
package thal_pkg;
    localparam int NCH = 2;
    localparam int SEL_W = 3;
    localparam int CFG_MASK_BIT = 7;
    localparam int CFG_FAN_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_HI1 = 3'd0,
        SEL_LO1 = 3'd1,
        SEL_HI2 = 3'd2,
        SEL_LO2 = 3'd3,
        SEL_CFG = 3'd4
    } sel_e;
endpackage

// File: rtl/thal_limit_regs.sv
module thal_limit_regs
    import thal_pkg::*;
#(
    parameter int TW       = 8,
    parameter int LO_RESET = -55
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [TW-1:0]            wr_data,
    output logic [NCH-1:0][TW-1:0]   hi_lim,
    output logic [NCH-1:0][TW-1:0]   lo_lim,
    output logic                     mask,
    output logic                     fan_en
);
    localparam logic [TW-1:0] HI_RST = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] LO_RST = LO_RESET[TW-1:0];

    typedef struct packed {
        logic [NCH-1:0][TW-1:0] hi;
        logic [NCH-1:0][TW-1:0] lo;
        logic                   mask;
        logic                   fan_en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_sel == SEL_W'(2 * ch))     regs_d.hi[ch] = wr_data;
                if (wr_sel == SEL_W'(2 * ch + 1)) regs_d.lo[ch] = wr_data;
            end
            if (wr_sel == SEL_CFG) begin
                regs_d.mask   = wr_data[CFG_MASK_BIT];
                regs_d.fan_en = wr_data[CFG_FAN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                regs_q.hi[ch] <= HI_RST;
                regs_q.lo[ch] <= LO_RST;
            end
            regs_q.mask   <= 1'b0;
            regs_q.fan_en <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign hi_lim = regs_q.hi;
    assign lo_lim = regs_q.lo;
    assign mask   = regs_q.mask;
    assign fan_en = regs_q.fan_en;

    // R9: a write with an unused select leaves every register unchanged
    a_r9_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_CFG) |=> $stable(regs_q));
endmodule

// File: rtl/thal_compare.sv
module thal_compare
    import thal_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic [NCH-1:0][TW-1:0] temp,
    input  logic [NCH-1:0][TW-1:0] hi_lim,
    input  logic [NCH-1:0][TW-1:0] lo_lim,
    input  logic                   diode_open,
    input  logic                   fan_fail,
    input  logic                   fan_en,
    output logic [NCH-1:0]         hi_ev,
    output logic [NCH-1:0]         lo_ev,
    output logic                   open_ev,
    output logic                   fan_ev
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            hi_ev[ch] = $signed(temp[ch]) >= $signed(hi_lim[ch]);
            lo_ev[ch] = $signed(temp[ch]) <= $signed(lo_lim[ch]);
        end
    end

    assign open_ev = diode_open;
    assign fan_ev  = fan_fail & fan_en;
endmodule

// File: rtl/thal_flags.sv
module thal_flags #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic          stat_rd,
    input  logic [FW-1:0] ev,
    output logic [FW-1:0] flags
);
    typedef struct packed {
        logic [FW-1:0] flags;
        logic [FW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd) st_d.flags = st_q.last;
        if (conv_done) begin
            st_d.flags = st_d.flags | ev;
            st_d.last  = ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R4: flags only move on a conversion or a status read
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !stat_rd) |=> $stable(st_q.flags));

    // R4: an event in a conversion cycle is always visible afterwards
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> ((st_q.flags & $past(ev)) == $past(ev)));
endmodule

// File: rtl/thal_alert_latch.sv
module thal_alert_latch #(
    parameter int          AW   = 7,
    parameter logic [AW:0] ADDR = 8'h3D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        conv_done,
    input  logic        temp_any,
    input  logic        fan_ev,
    input  logic        mask,
    input  logic        fan_en,
    input  logic        ara_rd,
    output logic        alert_n,
    output logic [AW:0] ara_data
);
    typedef struct packed {
        logic temp_al;
        logic fan_al;
    } al_t;

    al_t al_d, al_q;
    logic arm;
    logic active;

    always_comb begin
        arm  = conv_done & ~mask;
        al_d = al_q;
        if (ara_rd) begin
            al_d.temp_al = 1'b0;
            if (!fan_en) al_d.fan_al = 1'b0;
        end
        if (arm && temp_any) al_d.temp_al = 1'b1;
        if (arm && fan_ev)   al_d.fan_al  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    assign active   = (al_q.temp_al | al_q.fan_al) & ~mask;
    assign alert_n  = ~active;
    assign ara_data = active ? {ADDR[AW-1:0], 1'b0} : {(AW+1){1'b1}};

    // R5: a latched alert survives everything but an alert-response read
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((al_q.temp_al || al_q.fan_al) && !ara_rd) |=> (al_q.temp_al || al_q.fan_al));

    // R6: nothing gets latched while masked
    a_r6_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !al_q.temp_al && !al_q.fan_al) |=> (!al_q.temp_al && !al_q.fan_al));

    // R7: an alert-response read with no new conversion releases a temperature alert
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_rd && !conv_done) |=> !al_q.temp_al);

    // R8: a fan alert is kept while fan detection stays enabled
    a_r8_fan_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q.fan_al && fan_en) |=> al_q.fan_al);
endmodule

// File: rtl/thermal_alert_unit.sv
module thermal_alert_unit
    import thal_pkg::*;
#(
    parameter int          TW       = 8,
    parameter int          LO_RESET = -55,
    parameter logic [7:0]  ADDR     = 8'h3D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [TW-1:0] temp_ch1,
    input  logic [TW-1:0] temp_ch2,
    input  logic          diode_open,
    input  logic          fan_fail,
    input  logic          busy,
    input  logic          stat_rd,
    input  logic          ara_rd,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic [7:0]    status,
    output logic          alert_n,
    output logic [7:0]    ara_data
);
    localparam int FW = 2 * NCH + 2;

    logic [NCH-1:0][TW-1:0] temp;
    logic [NCH-1:0][TW-1:0] hi_lim;
    logic [NCH-1:0][TW-1:0] lo_lim;
    logic                   mask;
    logic                   fan_en;
    logic [NCH-1:0]         hi_ev;
    logic [NCH-1:0]         lo_ev;
    logic                   open_ev;
    logic                   fan_ev;
    logic [FW-1:0]          ev;
    logic [FW-1:0]          flags;
    logic                   temp_any;

    assign temp = {temp_ch2, temp_ch1};

    thal_limit_regs #(.TW(TW), .LO_RESET(LO_RESET)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .hi_lim  (hi_lim),
        .lo_lim  (lo_lim),
        .mask    (mask),
        .fan_en  (fan_en)
    );

    thal_compare #(.TW(TW)) u_cmp (
        .temp       (temp),
        .hi_lim     (hi_lim),
        .lo_lim     (lo_lim),
        .diode_open (diode_open),
        .fan_fail   (fan_fail),
        .fan_en     (fan_en),
        .hi_ev      (hi_ev),
        .lo_ev      (lo_ev),
        .open_ev    (open_ev),
        .fan_ev     (fan_ev)
    );

    // flag order: {hi2, lo2, hi1, lo1, open, fan}
    assign ev       = {hi_ev[1], lo_ev[1], hi_ev[0], lo_ev[0], open_ev, fan_ev};
    assign temp_any = |hi_ev | |lo_ev | open_ev;

    thal_flags #(.FW(FW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .stat_rd   (stat_rd),
        .ev        (ev),
        .flags     (flags)
    );

    thal_alert_latch #(.AW(7), .ADDR(ADDR)) u_alert (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .temp_any  (temp_any),
        .fan_ev    (fan_ev),
        .mask      (mask),
        .fan_en    (fan_en),
        .ara_rd    (ara_rd),
        .alert_n   (alert_n),
        .ara_data  (ara_data)
    );

    assign status = {busy, flags[FW-1:1], 1'b0, flags[0]};

    // R6: the mask bit holds the output released
    a_r6_mask_out: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> alert_n);

    // R7: an active alert always answers with the bus address
    a_r7_ara_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> (ara_data == {ADDR[6:0], 1'b0}));
endmodule

// File: tb/sim_thermal_alert_unit.sv
module sim_thermal_alert_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] temp_ch1 = '0;
    logic [7:0] temp_ch2 = '0;
    logic       diode_open = 1'b0;
    logic       fan_fail = 1'b0;
    logic       busy = 1'b0;
    logic       stat_rd = 1'b0;
    logic       ara_rd = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic       alert_n;
    logic [7:0] ara_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    thermal_alert_unit u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .temp_ch1(temp_ch1), .temp_ch2(temp_ch2),
        .diode_open(diode_open), .fan_fail(fan_fail), .busy(busy),
        .stat_rd(stat_rd), .ara_rd(ara_rd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status(status), .alert_n(alert_n), .ara_data(ara_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic conv(input int a, input int b, input bit op, input bit ff,
                        input bit rd, input bit ar);
        @(negedge clk);
        temp_ch1 = 8'(a); temp_ch2 = 8'(b);
        diode_open = op; fan_fail = ff;
        conv_done = 1'b1; stat_rd = rd; ara_rd = ar;
        @(negedge clk);
        conv_done = 1'b0; stat_rd = 1'b0; ara_rd = 1'b0;
        diode_open = 1'b0; fan_fail = 1'b0;
    endtask

    task automatic strobe(input bit rd, input bit ar);
        @(negedge clk);
        stat_rd = rd; ara_rd = ar;
        @(negedge clk);
        stat_rd = 1'b0; ara_rd = 1'b0;
    endtask

    task automatic wreg(input int sel, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected status bits 6..3 {hi2, lo2, hi1, lo1}
    function automatic int exp_tf(int a, int b, int h1, int l1, int h2, int l2);
        return ((b >= h2) << 3) | ((b <= l2) << 2) | ((a >= h1) << 1) | (a <= l1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 alert_n", alert_n, 1);
        chk("R1 ara_data", ara_data, 8'hFF);

        // R9 invalid selects write nothing; R1 default limits
        wreg(5, 0); wreg(6, 0); wreg(7, 8'h80);
        conv(126, -54, 0, 0, 0, 0);
        chk("R1 R9 default limits just inside", status[6:3], 0);
        chk("R1 unmasked no event", alert_n, 1);
        conv(127, -55, 0, 0, 0, 0);
        chk("R1 default limits trip", status[6:3], 4'b0110);
        chk("R5 alert set", alert_n, 0);
        chk("R7 ara addr", ara_data, 8'h7A);
        strobe(1, 0);
        chk("R5 status read keeps alert", alert_n, 0);
        chk("R4 read keeps live flags", status[6:3], 4'b0110);
        strobe(0, 1);
        chk("R7 ara releases", alert_n, 1);
        chk("R7 idle ara byte", ara_data, 8'hFF);
        conv(0, 0, 0, 0, 0, 0);
        strobe(1, 0);
        chk("R4 read clears", status, 0);

        // R6 R9 sweep with mask set
        wreg(4, 8'h81);
        wreg(0, 20); wreg(1, -10); wreg(2, 50); wreg(3, -30);
        for (int t = -128; t < 128; t++) begin
            conv(t, t, 0, 0, 0, 0);
            chk($sformatf("R2 R3 sweep t=%0d", t), status[6:3],
                exp_tf(t, t, 20, -10, 50, -30));
            chk("R6 masked", alert_n, 1);
            conv(0, 0, 0, 0, 0, 0);
            strobe(1, 0);
            chk("R4 sweep clear", status[6:3], 0);
        end

        // R2 no event without conv_done
        @(negedge clk);
        temp_ch1 = 8'd100; temp_ch2 = 8'd100; diode_open = 1'b1;
        repeat (3) @(negedge clk);
        diode_open = 1'b0;
        chk("R2 no conv no flags", status, 0);

        // R4 sticky then set-wins with a read
        conv(30, 0, 0, 0, 0, 0);
        conv(0, 0, 0, 0, 0, 0);
        chk("R4 sticky", status[6:3], 4'b0010);
        conv(0, -40, 0, 0, 1, 0);
        chk("R4 set wins over read", status[6:3], 4'b0100);

        // R3 busy bit and reserved bit
        @(negedge clk); busy = 1'b1; #1;
        chk("R3 busy", status[7], 1);
        chk("R3 reserved", status[1], 0);
        @(negedge clk); busy = 1'b0; #1;
        chk("R3 busy low", status[7], 0);
        conv(0, 0, 0, 0, 0, 0); strobe(1, 0);

        // R6 unmask: no retroactive alert
        wreg(4, 8'h01);
        chk("R6 unmasked idle", alert_n, 1);

        // R3 open diode flag and alert
        conv(0, 0, 1, 0, 0, 0);
        chk("R3 open bit", status, 8'h04);
        chk("R5 open alert", alert_n, 0);
        conv(30, 0, 0, 0, 0, 1);
        chk("R7 set wins over ara", alert_n, 0);
        strobe(0, 1);
        chk("R7 release", alert_n, 1);
        conv(0, 0, 0, 0, 0, 0); strobe(1, 0);

        // R6 masking hides a latched alert
        conv(30, 0, 0, 0, 0, 0);
        wreg(4, 8'h81);
        chk("R6 mask hides", alert_n, 1);
        chk("R6 mask ara", ara_data, 8'hFF);
        wreg(4, 8'h01);
        chk("R6 unmask shows latch", alert_n, 0);
        strobe(1, 1);
        conv(0, 0, 0, 0, 0, 0); strobe(1, 0);

        // R8 fan alert
        conv(0, 0, 0, 1, 0, 0);
        chk("R3 R8 fan bit", status, 8'h01);
        chk("R8 fan alert", alert_n, 0);
        strobe(0, 1);
        chk("R8 kept while enabled", alert_n, 0);
        wreg(4, 8'h00);
        chk("R8 still latched", alert_n, 0);
        strobe(0, 1);
        chk("R8 released", alert_n, 1);
        conv(0, 0, 0, 0, 0, 0); strobe(1, 0);
        conv(0, 0, 0, 1, 0, 0);
        chk("R8 detect off no flag", status, 0);
        chk("R8 detect off no alert", alert_n, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule